// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that completes one instruction per clock. On each cycle it presents a word address to an instruction port and receives the instruction word back in the same cycle. It decodes the instruction, reads up to two operands from a 32-entry register file and computes a result. In that same cycle it either writes the result back, drives a store onto the data port, or redirects the program counter. The data port carries a byte address, write data, four byte enables and a write strobe. Load data must come back combinationally in the same cycle.

The core supports a fixed integer subset: add, subtract, signed compare, OR with an immediate, load-upper, word and byte loads and stores, two conditional branches, an absolute jump, a jump through a register and a call that saves its return address. It is meant to sit next to small local memories. There is no pipeline, no branch delay slot and no trap handling. An unknown encoding does nothing except advance the program counter.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to zero and clears every register. The first fetch after reset is from word address 0.
- R2: Register 0 always reads as zero. An instruction that names register 0 as its destination leaves it at zero.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0] and jump field [25:0]. Opcode 0 selects by funct: 32 writes rs+rt to rd, 34 writes rs-rt to rd, and 42 writes 1 to rd if rs<rt as signed values and 0 otherwise. Add and subtract wrap without overflow detection.
- R4: Opcode 8 writes rs plus the sign-extended immediate to rt. Opcode 10 writes 1 to rt if rs is below the sign-extended immediate as signed values, and 0 otherwise. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R5: Opcode 15 writes the immediate into bits [31:16] of rt and clears bits [15:0].
- R6: The effective address is rs plus the sign-extended immediate. Opcode 35 loads that word into rt. Opcode 43 stores rt to that address with the strobe high and all four byte enables set.
- R7: Opcode 32 loads one byte into rt, sign-extended to 32 bits. Address bits [1:0] select the byte lane in little-endian order, so lane 0 is bits [7:0].
- R8: Opcode 40 stores the low byte of rt. Only the enable of the lane picked by address bits [1:0] is set, and the byte is repeated on all four lanes of the write data.
- R9: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch moves to PC+4 plus the sign-extended immediate shifted left by two. An untaken branch moves to PC+4.
- R10: Opcode 2 jumps to {PC+4 bits [31:28], jump field, 2'b00}. A jump field of 2500 from PC 0 gives byte address 10000, which is word address 2500.
- R11: Opcode 3 jumps like opcode 2 and, in the same cycle, writes PC+4 into register 31. Opcode 0 with funct 8 loads the program counter from rs.
- R12: Any other opcode, or opcode 0 with any other funct, writes no register, performs no store and advances the program counter by 4.
- R13: Whenever no store is executing, the write strobe is low and all byte enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | output | 30 | Word address of the current instruction (PC bits [31:2]) |
| fetch_instr | input | 32 | Instruction word returned for `fetch_word` in the same cycle |
| dm_addr | output | 32 | Byte address for loads and stores |
| dm_wdata | output | 32 | Store data, lane n on bits [8n+7:8n] |
| dm_be | output | 4 | Per-lane write enables |
| dm_we | output | 1 | Store strobe |
| dm_rdata | input | 32 | Load data for `dm_addr`, combinational |

## Verification
The hardest behaviour to reach from the ports is state that never leaves the core directly. This covers register contents, the ignored write to register 0, the link value and the result of an undefined instruction. The stimulus is a hand-built program that stores each of these values to memory, so a change shows up on the store bus and in the final memory image. The byte paths are exercised with a negative byte on lane 0 and two byte stores into different lanes of one word. The control paths are exercised with a branch that skips an instruction, a call and return, and a jump over a store that would corrupt a checked word. The long absolute jump to word 2500 is run in a separate phase. A second reset then proves that the program counter is cleared from a non-zero value.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 32;
    localparam int RIDX     = $clog2(NREG);
    localparam int LINK_REG = NREG - 1;
    localparam int IMMW     = 16;
    localparam int TGTW     = 26;
    localparam int NLANE    = XLEN / 8;

    typedef enum logic [5:0] {
        OP_SPECIAL = 6'd0,
        OP_J       = 6'd2,
        OP_JAL     = 6'd3,
        OP_BEQ     = 6'd4,
        OP_BNE     = 6'd5,
        OP_ADDI    = 6'd8,
        OP_SLTI    = 6'd10,
        OP_ORI     = 6'd13,
        OP_LUI     = 6'd15,
        OP_LB      = 6'd32,
        OP_LW      = 6'd35,
        OP_SB      = 6'd40,
        OP_SW      = 6'd43
    } opcode_e;

    typedef enum logic [5:0] {
        FN_JR  = 6'd8,
        FN_ADD = 6'd32,
        FN_SUB = 6'd34,
        FN_SLT = 6'd42
    } funct_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_OR,
        ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SEXT,
        IMM_ZEXT,
        IMM_UPPER
    } imm_kind_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_WORD,
        WB_BYTE,
        WB_LINK
    } wb_sel_e;

    typedef enum logic [1:0] {
        DST_RD,
        DST_RT,
        DST_LINK
    } dst_sel_e;

    typedef struct packed {
        alu_op_e   alu_op;
        imm_kind_e imm_kind;
        logic      use_imm;
        wb_sel_e   wb_sel;
        dst_sel_e  dst_sel;
        logic      reg_we;
        logic      mem_we;
        logic      mem_byte;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
        logic      jump_reg;
        logic      illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        alu_op:   ALU_ADD,
        imm_kind: IMM_SEXT,
        use_imm:  1'b0,
        wb_sel:   WB_ALU,
        dst_sel:  DST_RD,
        reg_we:   1'b0,
        mem_we:   1'b0,
        mem_byte: 1'b0,
        br_eq:    1'b0,
        br_ne:    1'b0,
        jump:     1'b0,
        jump_reg: 1'b0,
        illegal:  1'b0
    };

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        case (opcode)
            OP_SPECIAL: begin
                case (funct)
                    FN_ADD: begin
                        ctrl.alu_op = ALU_ADD;
                        ctrl.reg_we = 1'b1;
                    end
                    FN_SUB: begin
                        ctrl.alu_op = ALU_SUB;
                        ctrl.reg_we = 1'b1;
                    end
                    FN_SLT: begin
                        ctrl.alu_op = ALU_SLT;
                        ctrl.reg_we = 1'b1;
                    end
                    FN_JR: begin
                        ctrl.jump_reg = 1'b1;
                    end
                    default: begin
                        ctrl.illegal = 1'b1;
                    end
                endcase
            end
            OP_ADDI: begin
                ctrl.alu_op  = ALU_ADD;
                ctrl.use_imm = 1'b1;
                ctrl.dst_sel = DST_RT;
                ctrl.reg_we  = 1'b1;
            end
            OP_SLTI: begin
                ctrl.alu_op  = ALU_SLT;
                ctrl.use_imm = 1'b1;
                ctrl.dst_sel = DST_RT;
                ctrl.reg_we  = 1'b1;
            end
            OP_ORI: begin
                ctrl.alu_op   = ALU_OR;
                ctrl.imm_kind = IMM_ZEXT;
                ctrl.use_imm  = 1'b1;
                ctrl.dst_sel  = DST_RT;
                ctrl.reg_we   = 1'b1;
            end
            OP_LUI: begin
                ctrl.alu_op   = ALU_PASSB;
                ctrl.imm_kind = IMM_UPPER;
                ctrl.use_imm  = 1'b1;
                ctrl.dst_sel  = DST_RT;
                ctrl.reg_we   = 1'b1;
            end
            OP_LW: begin
                ctrl.use_imm = 1'b1;
                ctrl.dst_sel = DST_RT;
                ctrl.wb_sel  = WB_WORD;
                ctrl.reg_we  = 1'b1;
            end
            OP_LB: begin
                ctrl.use_imm = 1'b1;
                ctrl.dst_sel = DST_RT;
                ctrl.wb_sel  = WB_BYTE;
                ctrl.reg_we  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_SB: begin
                ctrl.use_imm  = 1'b1;
                ctrl.mem_we   = 1'b1;
                ctrl.mem_byte = 1'b1;
            end
            OP_BEQ: begin
                ctrl.br_eq = 1'b1;
            end
            OP_BNE: begin
                ctrl.br_ne = 1'b1;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            OP_JAL: begin
                ctrl.jump    = 1'b1;
                ctrl.wb_sel  = WB_LINK;
                ctrl.dst_sel = DST_LINK;
                ctrl.reg_we  = 1'b1;
            end
            default: begin
                ctrl.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         less;

    always_comb begin
        sum  = a + b;
        diff = a - b;
        less = ($signed(a) < $signed(b));
        case (op)
            ALU_ADD:   y = sum;
            ALU_SUB:   y = diff;
            ALU_SLT:   y = {{(W-1){1'b0}}, less};
            ALU_OR:    y = a | b;
            ALU_PASSB: y = b;
            default:   y = sum;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int N  = 32,
    parameter int W  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rs_a,
    input  logic [AW-1:0] rt_a,
    output logic [W-1:0]  rs_v,
    output logic [W-1:0]  rt_v,
    input  logic          wen,
    input  logic [AW-1:0] w_a,
    input  logic [W-1:0]  w_v
);

    logic [W-1:0] bank_q [N];
    logic [W-1:0] bank_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            bank_d[i] = bank_q[i];
        end
        if (wen && (w_a != '0)) begin
            bank_d[w_a] = w_v;
        end
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                bank_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign rs_v = bank_q[rs_a];
    assign rt_v = bank_q[rt_a];

    // R2: entry 0 never becomes non-zero
    p_zero_reg_r2: assert property (@(posedge clk) disable iff (rst)
        (rs_a == '0) |-> (rs_v == '0));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [XLEN-3:0]  fetch_word,
    input  logic [XLEN-1:0]  fetch_instr,
    output logic [XLEN-1:0]  dm_addr,
    output logic [XLEN-1:0]  dm_wdata,
    output logic [NLANE-1:0] dm_be,
    output logic             dm_we,
    input  logic [XLEN-1:0]  dm_rdata
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    ctrl_t            ctl;
    logic [5:0]       f_op;
    logic [5:0]       f_fn;
    logic [RIDX-1:0]  f_rs, f_rt, f_rd;
    logic [IMMW-1:0]  f_imm;
    logic [TGTW-1:0]  f_tgt;

    logic [XLEN-1:0]  rs_v, rt_v;
    logic [XLEN-1:0]  imm_ext, alu_b, alu_y;
    logic [XLEN-1:0]  pc_seq, br_off, ld_byte;
    logic [XLEN-1:0]  wb_val;
    logic [RIDX-1:0]  wb_addr;
    logic [1:0]       lane;
    logic [7:0]       byte_sel;
    logic             rs_eq, take_br;

    assign f_op  = fetch_instr[31:26];
    assign f_rs  = fetch_instr[25:21];
    assign f_rt  = fetch_instr[20:16];
    assign f_rd  = fetch_instr[15:11];
    assign f_fn  = fetch_instr[5:0];
    assign f_imm = fetch_instr[IMMW-1:0];
    assign f_tgt = fetch_instr[TGTW-1:0];

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .ctrl   (ctl)
    );

    sc_regfile #(
        .N (NREG),
        .W (XLEN)
    ) u_rf (
        .clk  (clk),
        .rst  (rst),
        .rs_a (f_rs),
        .rt_a (f_rt),
        .rs_v (rs_v),
        .rt_v (rt_v),
        .wen  (ctl.reg_we),
        .w_a  (wb_addr),
        .w_v  (wb_val)
    );

    always_comb begin
        case (ctl.imm_kind)
            IMM_ZEXT:  imm_ext = {{(XLEN-IMMW){1'b0}}, f_imm};
            IMM_UPPER: imm_ext = {f_imm, {(XLEN-IMMW){1'b0}}};
            default:   imm_ext = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
        endcase
    end

    assign alu_b = ctl.use_imm ? imm_ext : rt_v;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .op (ctl.alu_op),
        .a  (rs_v),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign pc_seq = st_q.pc + XLEN'(4);
    assign br_off = {{(XLEN-IMMW-2){f_imm[IMMW-1]}}, f_imm, 2'b00};
    assign rs_eq  = (rs_v == rt_v);
    assign take_br = (ctl.br_eq & rs_eq) | (ctl.br_ne & ~rs_eq);

    // load lane selection, little-endian
    assign lane = alu_y[1:0];

    always_comb begin
        case (lane)
            2'd0:    byte_sel = dm_rdata[7:0];
            2'd1:    byte_sel = dm_rdata[15:8];
            2'd2:    byte_sel = dm_rdata[23:16];
            default: byte_sel = dm_rdata[31:24];
        endcase
        ld_byte = {{(XLEN-8){byte_sel[7]}}, byte_sel};
    end

    always_comb begin
        case (ctl.wb_sel)
            WB_WORD: wb_val = dm_rdata;
            WB_BYTE: wb_val = ld_byte;
            WB_LINK: wb_val = pc_seq;
            default: wb_val = alu_y;
        endcase
        case (ctl.dst_sel)
            DST_RT:   wb_addr = f_rt;
            DST_LINK: wb_addr = RIDX'(LINK_REG);
            default:  wb_addr = f_rd;
        endcase
    end

    // store lanes
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign dm_be[g] = ctl.mem_we & (~ctl.mem_byte | (lane == 2'(g)));
        assign dm_wdata[8*g +: 8] = ctl.mem_byte ? rt_v[7:0] : rt_v[8*g +: 8];
    end

    assign dm_we   = ctl.mem_we;
    assign dm_addr = alu_y;

    // next state
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctl.jump_reg) begin
            st_d.pc = rs_v;
        end else if (ctl.jump) begin
            st_d.pc = {pc_seq[XLEN-1:XLEN-4], f_tgt, 2'b00};
        end else if (take_br) begin
            st_d.pc = pc_seq + br_off;
        end else begin
            st_d.pc = pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_word = st_q.pc[XLEN-1:2];

    // R1: first cycle out of reset fetches from zero
    p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.pc == '0));

    // R9: no redirect means a plain 4-byte step
    p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.jump && !ctl.jump_reg && !take_br) |=> (st_q.pc == $past(st_q.pc) + XLEN'(4)));

    // R10: jump field lands in PC bits [27:2]
    p_jump_target_r10: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> (st_q.pc[27:0] == {$past(f_tgt), 2'b00}));

    // R11: call writes the return address to the link register
    p_link_r11: assert property (@(posedge clk) disable iff (rst)
        (ctl.jump && ctl.reg_we) |-> (wb_addr == RIDX'(LINK_REG) && wb_val == st_q.pc + XLEN'(4)));

    // R12: unknown encodings are quiet
    p_nop_r12: assert property (@(posedge clk) disable iff (rst)
        ctl.illegal |-> (!dm_we && !ctl.reg_we && !ctl.jump && !ctl.jump_reg && !take_br));

    // R8: byte store enables exactly one lane
    p_byte_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (dm_we && ctl.mem_byte) |-> ($countones(dm_be) == 1));

    // R13: enables are silent without a store
    p_quiet_bus_r13: assert property (@(posedge clk) disable iff (rst)
        !dm_we |-> (dm_be == '0));

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] fetch_word;
    logic [31:0] fetch_instr;
    logic [31:0] dm_addr, dm_wdata, dm_rdata;
    logic [3:0]  dm_be;
    logic        dm_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [256];
    logic [31:0] mmem [256];
    logic [31:0] mreg [32];
    logic [31:0] mpc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    assign fetch_instr = imem[fetch_word[5:0]];
    assign dm_rdata    = dmem[dm_addr[9:2]];

    sc_core u_dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_word  (fetch_word),
        .fetch_instr (fetch_instr),
        .dm_addr     (dm_addr),
        .dm_wdata    (dm_wdata),
        .dm_be       (dm_be),
        .dm_we       (dm_we),
        .dm_rdata    (dm_rdata)
    );

    function automatic logic [31:0] r_ins(int rs, int rt, int rd, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] i_ins(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] j_ins(int op, int tgt);
        return {op[5:0], tgt[25:0]};
    endfunction

    function automatic string tag_of(logic [5:0] op, logic [5:0] fn);
        case (op)
            6'd0:                 return (fn == 6'd8) ? "R11" :
                                         ((fn == 6'd32 || fn == 6'd34 || fn == 6'd42) ? "R3" : "R12");
            6'd8, 6'd10, 6'd13:   return "R4";
            6'd15:                return "R5";
            6'd35, 6'd43:         return "R6";
            6'd32:                return "R7";
            6'd40:                return "R8";
            6'd4, 6'd5:           return "R9";
            6'd2:                 return "R10";
            6'd3:                 return "R11";
            default:              return "R12";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
        mpc = 32'h0;
    endtask

    // compare the current cycle, then advance the reference by one instruction
    task automatic model_cycle();
        logic [31:0] ins, a, b, sx, zx, pc4, nxt, ea, word, res, ewd;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, wi;
        logic [3:0]  ebe;
        logic [7:0]  bt;
        logic        wen, ewe;
        string       tg;
        ins = imem[mpc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a = mreg[rs]; b = mreg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'h0, ins[15:0]};
        pc4 = mpc + 32'd4; nxt = pc4; ea = a + sx;
        wen = 1'b0; wi = 5'd0; res = 32'h0; ewe = 1'b0; ebe = 4'h0; ewd = 32'h0;
        tg = tag_of(op, fn);
        case (op)
            6'd0: case (fn)
                6'd32: begin wen = 1'b1; wi = rd; res = a + b; end
                6'd34: begin wen = 1'b1; wi = rd; res = a - b; end
                6'd42: begin wen = 1'b1; wi = rd; res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
                6'd8:  nxt = a;
                default: ;
            endcase
            6'd8:  begin wen = 1'b1; wi = rt; res = a + sx; end
            6'd10: begin wen = 1'b1; wi = rt; res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
            6'd13: begin wen = 1'b1; wi = rt; res = a | zx; end
            6'd15: begin wen = 1'b1; wi = rt; res = {ins[15:0], 16'h0}; end
            6'd35: begin wen = 1'b1; wi = rt; res = mmem[ea[9:2]]; end
            6'd32: begin
                word = mmem[ea[9:2]];
                bt = word[8*ea[1:0] +: 8];
                wen = 1'b1; wi = rt; res = {{24{bt[7]}}, bt};
            end
            6'd43: begin ewe = 1'b1; ebe = 4'hF; ewd = b; end
            6'd40: begin ewe = 1'b1; ebe = 4'b0001 << ea[1:0]; ewd = {4{b[7:0]}}; end
            6'd4:  if (a == b) nxt = pc4 + {sx[29:0], 2'b00};
            6'd5:  if (a != b) nxt = pc4 + {sx[29:0], 2'b00};
            6'd2:  nxt = {pc4[31:28], ins[25:0], 2'b00};
            6'd3:  begin nxt = {pc4[31:28], ins[25:0], 2'b00}; wen = 1'b1; wi = 5'd31; res = pc4; end
            default: ;
        endcase
        chk({tg, " fetch"}, {2'b00, fetch_word}, {2'b00, mpc[31:2]});
        chk(ewe ? {tg, " strobe"} : "R13 strobe", {31'd0, dm_we}, {31'd0, ewe});
        if (ewe) begin
            chk({tg, " enables"}, {28'd0, dm_be}, {28'd0, ebe});
            chk({tg, " address"}, dm_addr, ea);
            chk({tg, " wdata"}, dm_wdata, ewd);
        end else begin
            chk("R13 enables", {28'd0, dm_be}, 32'd0);
        end
        if (dm_we) begin
            for (int l = 0; l < 4; l++)
                if (dm_be[l]) dmem[dm_addr[9:2]][8*l +: 8] = dm_wdata[8*l +: 8];
        end
        if (ewe) begin
            for (int l = 0; l < 4; l++)
                if (ebe[l]) mmem[ea[9:2]][8*l +: 8] = ewd[8*l +: 8];
        end
        if (wen && wi != 5'd0) mreg[wi] = res;
        mpc = nxt;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++)  imem[i] = 32'h0;
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 32'hDEADBEEF;
            mmem[i] = 32'hDEADBEEF;
        end

        // phase 1: long absolute jump
        imem[0] = j_ins(2, 2500);
        do_reset();
        chk("R1 reset fetch", {2'b00, fetch_word}, 32'd0);
        model_cycle();
        @(negedge clk);
        chk("R10 jump 2500", {2'b00, fetch_word}, 32'd2500);

        // phase 2: program
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        imem[0]  = i_ins(8, 0, 1, 5);
        imem[1]  = i_ins(8, 0, 2, -3);
        imem[2]  = r_ins(1, 2, 3, 32);
        imem[3]  = r_ins(2, 1, 4, 34);
        imem[4]  = r_ins(2, 1, 5, 42);
        imem[5]  = r_ins(1, 2, 6, 42);
        imem[6]  = i_ins(13, 0, 7, 16'h8000);
        imem[7]  = i_ins(15, 0, 8, 16'h1234);
        imem[8]  = i_ins(13, 8, 8, 16'h5678);
        imem[9]  = i_ins(10, 2, 9, -1);
        imem[10] = i_ins(8, 1, 0, 7);
        imem[11] = i_ins(8, 0, 10, 16'h100);
        for (int k = 0; k < 7; k++) imem[12+k] = i_ins(43, 10, 3+k, 4*k);
        imem[19] = i_ins(43, 10, 0, 28);
        imem[20] = i_ins(32, 10, 11, 4);
        imem[21] = i_ins(32, 10, 12, 22);
        imem[22] = i_ins(40, 10, 11, 33);
        imem[23] = i_ins(40, 10, 12, 35);
        imem[24] = i_ins(43, 10, 12, 36);
        imem[25] = i_ins(43, 10, 11, 56);
        imem[26] = i_ins(35, 10, 13, 20);
        imem[27] = i_ins(4, 13, 8, 1);
        imem[28] = i_ins(8, 0, 14, 99);
        imem[29] = i_ins(5, 13, 8, 1);
        imem[30] = i_ins(8, 0, 15, 77);
        imem[31] = i_ins(43, 10, 15, 40);
        imem[32] = i_ins(43, 10, 14, 44);
        imem[33] = j_ins(3, 41);
        imem[34] = i_ins(43, 10, 31, 48);
        imem[35] = 32'hFC210001;
        imem[36] = r_ins(1, 1, 1, 63);
        imem[37] = i_ins(43, 10, 1, 52);
        imem[38] = j_ins(2, 40);
        imem[39] = i_ins(43, 10, 0, 52);
        imem[40] = i_ins(4, 0, 0, -1);
        imem[41] = i_ins(8, 0, 16, 11);
        imem[42] = r_ins(31, 0, 0, 8);

        do_reset();
        chk("R1 reset from nonzero pc", {2'b00, fetch_word}, 32'd0);
        for (int c = 0; c < 70; c++) begin
            model_cycle();
            @(negedge clk);
        end

        chk("R3 add", dmem[64], 32'd2);
        chk("R3 sub wraps", dmem[65], 32'hFFFFFFF8);
        chk("R3 slt negative lt positive", dmem[66], 32'd1);
        chk("R3 slt positive vs negative", dmem[67], 32'd0);
        chk("R4 ori zero-extends", dmem[68], 32'h00008000);
        chk("R5 lui then ori", dmem[69], 32'h12345678);
        chk("R4 slti signed", dmem[70], 32'd1);
        chk("R2 write to reg0 ignored", dmem[71], 32'd0);
        chk("R8 byte stores into lanes 1 and 3", dmem[72], 32'h34ADF8EF);
        chk("R7 lb lane 2 positive", dmem[73], 32'h00000034);
        chk("R9 bne not taken", dmem[74], 32'd77);
        chk("R9 beq taken skips", dmem[75], 32'd0);
        chk("R11 link value", dmem[76], 32'd136);
        chk("R12 undefined ops are no-ops", dmem[77], 32'd5);
        chk("R7 lb lane 0 negative", dmem[78], 32'hFFFFFFF8);
        chk("R6 untouched word", dmem[79], 32'hDEADBEEF);
        chk("R9 halted on self branch", {2'b00, fetch_word}, 32'd40);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule